// File: doc/BRIEF.md
# Serial Configuration Load Port

This block receives configuration words over a three-wire serial link: a serial clock, a serial data line and a load strobe. Each rising edge of the serial clock shifts one data bit into a 22-bit shift register, most significant bit first. A rising edge on the load strobe copies the register into one of four configuration latches. The two bits received last, which sit at the low end of the word, pick the latch.

Only the upper 20 bits are stored. In the attached synthesizer these carry the counter settings: a 14-bit reference divide value, or a 17-bit main divide value made of a 6-bit and an 11-bit count. The block does not decode these fields. All three serial pins are sampled in the fast system clock domain through a two-flop synchronizer, and their edges are found there. The system clock must therefore run at least four times faster than the serial clock.

The four latched words are outputs, together with a one-cycle update strobe for each latch. Downstream logic can use the strobe to act on a new setting.

Top module: `ser_cfg_port`

## Requirements
- R1: While rst_ni is low, all four latch outputs and all update strobes are zero.
- R2: Each rising edge of ser_clk_i shifts the current ser_data_i bit into the low end of the shift register, so the first bit received ends up as word bit 21.
- R3: On a rising edge of ser_le_i, word bits 21..2 are stored in the latch whose index equals word bits 1..0: 0 is channel-2 reference divide, 1 is channel-2 main divide, 2 is channel-1 reference divide and 3 is channel-1 main divide.
- R4: A load leaves the three latches that were not selected unchanged.
- R5: A load raises exactly one update strobe, the one at the selected index, for one system clock cycle. That is the cycle in which the latch output first shows the new value, three system clock edges after ser_le_i rises.
- R6: If more than 22 bits are shifted before a load, only the last 22 received are used.
- R7: The shift register is not cleared by a load. If fewer than 22 bits are shifted before the next load, the upper bits still hold earlier data.
- R8: A load happens only on the rising edge of ser_le_i. Holding ser_le_i high causes no further loads or strobes.
- R9: Reset clears the shift register. A load after reset that follows only two shifted bits stores a zero payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, sampled asynchronously |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; rising edge transfers the word |
| latch_o | output | 4x20 | Latched payloads, index = select code |
| upd_o | output | 4 | One-cycle update strobe per latch |

## Verification
The hardest states to reach from the ports are those where the shift register holds something other than one clean 22-bit word. These arise from an overlong burst, a short burst that leaves stale upper bits, or a short burst right after reset. The bench reaches them by choosing burst lengths at random between 2 and 30 bits, and it keeps its own model of the shift register across loads, so leftover bits are predicted rather than avoided. Directed cases add a load held high for many cycles and a two-bit load just after a mid-run reset.

// File: rtl/ser_cfg_pkg.sv
`timescale 1ns/1ps
package ser_cfg_pkg;
  localparam int unsigned CFG_WORD_W = 22;
  localparam int unsigned CFG_SEL_W  = 2;
  localparam int unsigned CFG_SYNC_N = 2;

  typedef enum logic [CFG_SEL_W-1:0] {
    TGT_CH2_REF  = 2'd0,
    TGT_CH2_MAIN = 2'd1,
    TGT_CH1_REF  = 2'd2,
    TGT_CH1_MAIN = 2'd3
  } cfg_tgt_e;
endpackage

// File: rtl/ser_cfg_sync.sv
`timescale 1ns/1ps
module ser_cfg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ser_cfg_shift.sv
`timescale 1ns/1ps
module ser_cfg_shift #(
  parameter int unsigned WORD_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[WORD_W-2:0], bit_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/ser_cfg_bank.sv
`timescale 1ns/1ps
module ser_cfg_bank #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned PAY_W = 20,
  localparam int unsigned NUM  = 1 << SEL_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic [SEL_W-1:0]          sel_i,
  input  logic [PAY_W-1:0]          pay_i,
  output logic [NUM-1:0][PAY_W-1:0] lat_o,
  output logic [NUM-1:0]            upd_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_lat
    logic hit;
    assign hit = load_i && (sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_o[g] <= '0;
        upd_o[g] <= 1'b0;
      end else begin
        upd_o[g] <= hit;
        if (hit) lat_o[g] <= pay_i;
      end
    end
  end
endmodule

// File: rtl/ser_cfg_port.sv
`timescale 1ns/1ps
module ser_cfg_port
  import ser_cfg_pkg::*;
#(
  parameter int unsigned WORD_W  = CFG_WORD_W,
  parameter int unsigned SEL_W   = CFG_SEL_W,
  parameter int unsigned SYNC_N  = CFG_SYNC_N,
  localparam int unsigned PAY_W  = WORD_W - SEL_W,
  localparam int unsigned NUM    = 1 << SEL_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ser_clk_i,
  input  logic                      ser_data_i,
  input  logic                      ser_le_i,
  output logic [NUM-1:0][PAY_W-1:0] latch_o,
  output logic [NUM-1:0]            upd_o
);
  // bit 2: serial clock, bit 1: load, bit 0: data
  logic [2:0] pins_s;
  logic [1:0] edge_q;
  logic       shift_en, load_en;
  logic [WORD_W-1:0] word;

  ser_cfg_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ser_clk_i, ser_le_i, ser_data_i}),
    .sync_o  (pins_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edge_q <= '0;
    else         edge_q <= pins_s[2:1];
  end

  assign shift_en = pins_s[2] & ~edge_q[1];
  assign load_en  = pins_s[1] & ~edge_q[0];

  ser_cfg_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .bit_i   (pins_s[0]),
    .word_o  (word)
  );

  // load samples the word as it stood before any same-cycle shift
  ser_cfg_bank #(.SEL_W(SEL_W), .PAY_W(PAY_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_en),
    .sel_i  (word[SEL_W-1:0]),
    .pay_i  (word[WORD_W-1:SEL_W]),
    .lat_o  (latch_o),
    .upd_o  (upd_o)
  );
endmodule

// File: rtl/ser_cfg_port_chk.sv
`timescale 1ns/1ps
module ser_cfg_port_chk #(
  parameter int unsigned NUM   = 4,
  parameter int unsigned PAY_W = 20
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM-1:0][PAY_W-1:0] latch_o,
  input logic [NUM-1:0]            upd_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (latch_o == '0 && upd_o == '0));

  // R5
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(upd_o));

  for (genvar g = 0; g < NUM; g++) begin : g_chk
    // R4
    change_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(latch_o[g]) |-> upd_o[g]);

    // R8
    strobe_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_o[g] |=> !upd_o[g]);
  end
endmodule

bind ser_cfg_port ser_cfg_port_chk #(.NUM(NUM), .PAY_W(PAY_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .latch_o (latch_o),
  .upd_o   (upd_o)
);

// File: tb/ser_cfg_port_tb.sv
`timescale 1ns/1ps
module ser_cfg_port_tb;
  localparam int W = 22, PW = 20, N = 4;

  logic clk = 0, rst_n = 1, sclk = 0, sdat = 0, sle = 0;
  logic [N-1:0][PW-1:0] lat;
  logic [N-1:0]         upd;
  logic [W-1:0]  sh_m;
  logic [PW-1:0] lat_m [N];
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  ser_cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat),
    .ser_le_i(sle), .latch_o(lat), .upd_o(upd)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] onehot(int idx);
    return N'(1) << idx;
  endfunction

  task automatic check_all(int sel);
    for (int i = 0; i < N; i++)
      chk(i == sel ? "R3" : "R4", $sformatf("latch %0d", i), 32'(lat[i]), 32'(lat_m[i]));
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    sh_m = '0;
    for (int i = 0; i < N; i++) lat_m[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", 32'(upd), 0);
    for (int i = 0; i < N; i++) chk("R1", "latch in reset", 32'(lat[i]), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    @(negedge clk) sdat = b; sclk = 0;
    repeat (3) @(negedge clk);
    sclk = 1;
    repeat (4) @(negedge clk);
    sclk = 0;
    sh_m = {sh_m[W-2:0], b};
  endtask

  task automatic send_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic load(string req, int hold);
    int idx;
    @(negedge clk) sle = 1;
    idx = int'(sh_m[1:0]);
    lat_m[idx] = sh_m[W-1:2];
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5", $sformatf("strobe (%s)", req), 32'(upd), 32'(onehot(idx)));
    check_all(idx);
    @(negedge clk);
    chk("R5", "strobe width", 32'(upd), 0);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (upd !== '0) chk("R8", "strobe while load held", 32'(upd), 0);
    end
    if (hold > 0) check_all(idx);
    sle = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int n;
    logic [31:0] v;
    void'($urandom(32'd1234));
    #1 rst_n = 0;
    do_reset();

    // R2: directed words, one per target
    send_bits({20'hABCDE, 2'b10}, W); load("R2", 0);
    chk("R2", "msb-first ch1 ref", 32'(lat[2]), 32'h0ABCDE);
    send_bits({20'h80001, 2'b00}, W); load("R2", 0);
    send_bits({20'hFFFFF, 2'b01}, W); load("R2", 0);
    send_bits({20'h5A5A5, 2'b11}, W); load("R2", 0);

    // R8: load held high for a long time
    send_bits({20'h13579, 2'b01}, W); load("R8", 40);

    // R6: overlong burst
    send_bits(32'hDEADBEEF, 30); load("R6", 0);
    // R7: short burst keeps stale upper bits
    send_bits(32'h6, 3); load("R7", 0);
    chk("R7", "stale upper bits", 32'(lat[int'(sh_m[1:0])]), 32'(sh_m[W-1:2]));

    // R9: reset clears shift register
    do_reset();
    send_bits(32'h3, 2); load("R9", 0);
    chk("R9", "payload after reset", 32'(lat[3]), 0);

    // random bursts 2..30 bits
    for (int k = 0; k < 40; k++) begin
      n = 2 + int'($urandom_range(28));
      if ($urandom_range(3) != 0) n = W;
      v = $urandom();
      send_bits(v, n);
      load(n > W ? "R6" : (n < W ? "R7" : "R3"), int'($urandom_range(6)));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: got running expected done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule